// File: doc/BRIEF.md
# Zero-Suppression Channel Mask Builder

This block decides, once per event, which of 21 ADC channels are worth reading out. Each channel arrives with a bitmap of up to 64 samples. A bit in that bitmap is set where the front-end indicator logic saw something of interest. The block ANDs each bitmap with a global sample mask. A channel is kept when the result is nonzero, and the per-channel ANDed mask is also presented so that later logic can place the readout window.

The channels are organised as four groups: three groups of five and a last group of six. Each of the first three groups can report one track-segment descriptor. When the descriptor qualifies, a run of three or four adjacent channels is added to the selection. The merged selection then passes through an optional enable mask and an unconditional force-on mask. A periodic schedule, driven by the low bits of the event counter, can replace the indicator scan with a full readout of every channel.

A one-cycle start strobe captures all inputs. The registered mask and sample masks appear together with a one-cycle done pulse on the following cycle, and they hold until the next strobe.

Top module: `zs_chmask_top`

## Requirements
- R1: A channel's bit in `chan_mask` is set when the AND of its indicator bitmap and `smp_mask` is nonzero. Channel k's bitmap is `ind_bmp[k*64 +: 64]` and its result is bit k of `chan_mask`.
- R2: `and_masks[k*64 +: 64]` equals the AND of channel k's bitmap and `smp_mask`, as captured at the start strobe.
- R3: When the parameter NSAMPLES is 30 or less, bitmap bits 32..63 neither select a channel nor appear in `and_masks`. Bits 0..31 always take part.
- R4: When `cfg_full_n` is N in 1..3 and the low N bits of `evt_cnt` equal 1, the indicator scan is replaced by all 21 channels selected, and `and_masks` is all zero. When `cfg_full_n` is 0, full readout never happens.
- R5: Group g (0..3) owns `chan_mask` bits starting at 5*g. Groups 0..2 are 5 bits wide and group 3 is 6 bits wide (bits 15..20).
- R6: A track descriptor for group g (g in 0..2) holds a position field `trk_pos[g*5 +: 5]`, where 0 means no candidate and a value v means pair index p = v-1. A qualifying descriptor adds channels p, p+1 and p+2, and also p+3 when `trk_hits[g*4 +: 4]` is nonzero.
- R7: The `cfg_trk_mode` codes are: 0 adds nothing; 1 adds for any candidate; 2 adds only when `trk_word[g*32 +: 32]` differs from the end marker (default 32'hFFFF_FFFF); 3 behaves as 0.
- R8: Track-contribution bits that would land above channel 20 are discarded.
- R9: With `cfg_en_apply` = 1, the selection is ANDed with `en_mask`. With `cfg_en_apply` = 0, it is ANDed with all ones.
- R10: `force_mask` is ORed in after the enable step, so a forced channel is always selected.
- R11: `done` is high exactly in the cycle after `start` is sampled high. With no start strobe, `chan_mask` and `and_masks` hold their values. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture strobe for one event |
| evt_cnt | input | 16 | Event counter |
| cfg_full_n | input | 2 | Full-readout period exponent, 0 = off |
| cfg_trk_mode | input | 2 | Track contribution mode |
| cfg_en_apply | input | 1 | Apply enable mask |
| en_mask | input | 21 | Channel enable mask |
| force_mask | input | 21 | Channel force-on mask |
| smp_mask | input | 64 | Global sample mask |
| ind_bmp | input | 1344 | Indicator bitmaps, 64 bits per channel |
| trk_pos | input | 15 | Track position per group, pair index + 1 |
| trk_hits | input | 12 | Hit count of channel p+1 per group |
| trk_word | input | 96 | Emitted track word per group |
| chan_mask | output | 21 | Registered channel selection |
| and_masks | output | 1344 | Registered ANDed sample masks per channel |
| done | output | 1 | Result-valid pulse |

## Verification
On every cycle, the assertions check five things. The done pulse follows the start strobe by exactly one cycle. Forced channels always show up in the result. With the enable mask applied, nothing outside enable-or-force is selected. A full-readout event leaves the sample masks empty. With the enable step bypassed, every channel whose captured sample mask is nonzero is selected. Only the bench scenarios can show the rest: the exact channel sets produced by overlaps, track runs of three or four channels near the top edge, the end-marker rule, the short-sample variant, and holding of the outputs between strobes.

// File: rtl/zs_pkg.sv
package zs_pkg;
   typedef enum logic [1:0] {
      TRK_OFF  = 2'd0,
      TRK_ANY  = 2'd1,
      TRK_SENT = 2'd2,
      TRK_RSV  = 2'd3
   } trk_mode_e;

   function automatic logic [15:0] full_low_mask(input logic [1:0] n);
      full_low_mask = (16'd1 << n) - 16'd1;
   endfunction
endpackage

// File: rtl/zs_grp_scan.sv
module zs_grp_scan #(
   parameter int NW       = 5,
   parameter int SMP_W    = 64,
   parameter int NSAMPLES = 64
) (
   input  logic [NW*SMP_W-1:0] ind,
   input  logic [SMP_W-1:0]    smp,
   output logic [NW-1:0]       hit,
   output logic [NW*SMP_W-1:0] andm
);
   localparam int USE_W = (NSAMPLES > 30) ? SMP_W : 32;
   localparam logic [SMP_W-1:0] LIVE = {{(SMP_W-USE_W){1'b0}}, {USE_W{1'b1}}};

   logic [SMP_W-1:0] smp_eff;
   assign smp_eff = smp & LIVE;

   for (genvar c = 0; c < NW; c++) begin : g_ch
      assign andm[c*SMP_W +: SMP_W] = ind[c*SMP_W +: SMP_W] & smp_eff;
      assign hit[c] = |andm[c*SMP_W +: SMP_W];
   end
endmodule

// File: rtl/zs_trk_add.sv
module zs_trk_add
   import zs_pkg::*;
#(
   parameter int          NCH      = 21,
   parameter int          POS_W    = 5,
   parameter int          HIT_W    = 4,
   parameter logic [31:0] END_MARK = 32'hFFFF_FFFF
) (
   input  logic [1:0]       mode,
   input  logic [POS_W-1:0] pos,
   input  logic [HIT_W-1:0] hits,
   input  logic [31:0]      word,
   output logic [NCH-1:0]   add
);
   localparam int WIDE = NCH + (1 << POS_W) + 4;

   trk_mode_e        m;
   logic             qual;
   logic [WIDE-1:0]  run;
   logic [POS_W-1:0] p;

   always_comb begin
      m    = trk_mode_e'(mode);
      p    = pos - POS_W'(1);
      case (m)
         TRK_ANY:  qual = (pos != '0);
         TRK_SENT: qual = (pos != '0) && (word != END_MARK);
         default:  qual = 1'b0;
      endcase
      run  = (hits != '0) ? WIDE'(4'b1111) : WIDE'(4'b0111);
      run  = run << p;
      add  = qual ? run[NCH-1:0] : '0;
   end
endmodule

// File: rtl/zs_chmask_top.sv
module zs_chmask_top
   import zs_pkg::*;
#(
   parameter int          NGRP     = 4,
   parameter int          GRP_W    = 5,
   parameter int          SMP_W    = 64,
   parameter int          NSAMPLES = 64,
   parameter int          POS_W    = 5,
   parameter int          HIT_W    = 4,
   parameter logic [31:0] END_MARK = 32'hFFFF_FFFF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [15:0]                evt_cnt,
   input  logic [1:0]                 cfg_full_n,
   input  logic [1:0]                 cfg_trk_mode,
   input  logic                       cfg_en_apply,
   input  logic [20:0]                en_mask,
   input  logic [20:0]                force_mask,
   input  logic [63:0]                smp_mask,
   input  logic [21*64-1:0]           ind_bmp,
   input  logic [3*5-1:0]             trk_pos,
   input  logic [3*4-1:0]             trk_hits,
   input  logic [3*32-1:0]            trk_word,
   output logic [20:0]                chan_mask,
   output logic [21*64-1:0]           and_masks,
   output logic                       done
);
   localparam int NCH  = NGRP * GRP_W + 1;
   localparam int NTRK = NGRP - 1;

   if (NCH != 21 || SMP_W != 64 || POS_W != 5 || HIT_W != 4) begin : g_chk_shape
      $error("zs_chmask_top: port shape needs 4x5+1 channels, 64 samples");
   end
   if (NSAMPLES < 1 || NSAMPLES > SMP_W) begin : g_chk_ns
      $error("zs_chmask_top: NSAMPLES out of range");
   end

   logic [NCH-1:0]       scan_hit;
   logic [NCH*SMP_W-1:0] scan_and;
   logic [NCH-1:0]       trk_or;
   logic [NTRK*NCH-1:0]  trk_add;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int BASE = g * GRP_W;
      localparam int W    = GRP_W + ((g == NGRP - 1) ? 1 : 0);
      zs_grp_scan #(.NW(W), .SMP_W(SMP_W), .NSAMPLES(NSAMPLES)) u_scan (
         .ind  (ind_bmp[BASE*SMP_W +: W*SMP_W]),
         .smp  (smp_mask),
         .hit  (scan_hit[BASE +: W]),
         .andm (scan_and[BASE*SMP_W +: W*SMP_W])
      );
   end

   for (genvar t = 0; t < NTRK; t++) begin : g_trk
      zs_trk_add #(.NCH(NCH), .POS_W(POS_W), .HIT_W(HIT_W), .END_MARK(END_MARK)) u_trk (
         .mode (cfg_trk_mode),
         .pos  (trk_pos[t*POS_W +: POS_W]),
         .hits (trk_hits[t*HIT_W +: HIT_W]),
         .word (trk_word[t*32 +: 32]),
         .add  (trk_add[t*NCH +: NCH])
      );
   end

   always_comb begin
      trk_or = '0;
      for (int t = 0; t < NTRK; t++) trk_or = trk_or | trk_add[t*NCH +: NCH];
   end

   logic           full_evt;
   logic [NCH-1:0] sel_base, sel_final;

   always_comb begin
      full_evt  = (cfg_full_n != 2'd0) &&
                  ((evt_cnt & full_low_mask(cfg_full_n)) == 16'd1);
      sel_base  = (full_evt ? {NCH{1'b1}} : scan_hit) | trk_or;
      sel_final = (sel_base & (cfg_en_apply ? en_mask : {NCH{1'b1}})) | force_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_mask <= '0;
         and_masks <= '0;
         done      <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            chan_mask <= sel_final;
            and_masks <= full_evt ? '0 : scan_and;
         end
      end
   end

   logic [NCH-1:0] am_nz;
   for (genvar k = 0; k < NCH; k++) begin : g_nz
      assign am_nz[k] = |and_masks[k*SMP_W +: SMP_W];
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R11
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R11
   AST_FORCE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((chan_mask & $past(force_mask)) == $past(force_mask))); // R10
   AST_EN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg_en_apply) |=>
         ((chan_mask & ~($past(en_mask) | $past(force_mask))) == '0)); // R9
   AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && full_evt) |=> (am_nz == '0)); // R4
   AST_OVERLAP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cfg_en_apply) |=> ((am_nz & ~chan_mask) == '0)); // R1
endmodule

// File: tb/tb_zs_chmask_top.sv
module tb_zs_chmask_top;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [15:0]        evt_cnt = '0;
   logic [1:0]         cfg_full_n = '0;
   logic [1:0]         cfg_trk_mode = '0;
   logic               cfg_en_apply = 1'b0;
   logic [20:0]        en_mask = '0;
   logic [20:0]        force_mask = '0;
   logic [63:0]        smp_mask = '0;
   logic [21*64-1:0]   ind_bmp = '0;
   logic [14:0]        trk_pos = '0;
   logic [11:0]        trk_hits = '0;
   logic [95:0]        trk_word = '0;
   logic [20:0]        chan_mask, chan_mask_s;
   logic [21*64-1:0]   and_masks, and_masks_s;
   logic               done, done_s;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   zs_chmask_top dut (
      .clk, .rst_n, .start, .evt_cnt, .cfg_full_n, .cfg_trk_mode, .cfg_en_apply,
      .en_mask, .force_mask, .smp_mask, .ind_bmp, .trk_pos, .trk_hits, .trk_word,
      .chan_mask(chan_mask), .and_masks(and_masks), .done(done));

   zs_chmask_top #(.NSAMPLES(30)) dut_s (
      .clk, .rst_n, .start, .evt_cnt, .cfg_full_n, .cfg_trk_mode, .cfg_en_apply,
      .en_mask, .force_mask, .smp_mask, .ind_bmp, .trk_pos, .trk_hits, .trk_word,
      .chan_mask(chan_mask_s), .and_masks(and_masks_s), .done(done_s));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic fire();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic clear_in();
      ind_bmp = '0; smp_mask = '0; trk_pos = '0; trk_hits = '0; trk_word = '0;
      cfg_full_n = 0; cfg_trk_mode = 0; cfg_en_apply = 0; en_mask = '0;
      force_mask = '0; evt_cnt = '0;
   endtask

   task automatic t_reset();
      chk("R11 reset mask", 64'(chan_mask), 0);
      chk("R11 reset done", 64'(done), 0);
      chk("R11 reset and", and_masks[63:0], 0);
   endtask

   task automatic t_scan();
      clear_in();
      smp_mask = ~(64'd1 << 10);
      ind_bmp[0*64 + 3]  = 1'b1;
      ind_bmp[7*64 + 40] = 1'b1;
      ind_bmp[20*64 + 63] = 1'b1;
      ind_bmp[5*64 + 10] = 1'b1;
      fire();
      chk("R11 done pulse", 64'(done), 1);
      chk("R1 overlap select", 64'(chan_mask), 64'h100081);
      chk("R5 group3 top bit", 64'(chan_mask[20]), 1);
      chk("R2 and mask ch7", and_masks[7*64 +: 64], 64'd1 << 40);
      chk("R2 and mask ch5", and_masks[5*64 +: 64], 0);
      chk("R3 short select", 64'(chan_mask_s), 64'h1);
      chk("R3 short and ch7", and_masks_s[7*64 +: 64], 0);
      @(negedge clk);
      chk("R11 done single", 64'(done), 0);
   endtask

   task automatic t_full();
      clear_in();
      smp_mask = '1;
      ind_bmp[2*64] = 1'b1;
      cfg_full_n = 2; evt_cnt = 16'd5;
      fire();
      chk("R4 full all", 64'(chan_mask), 64'h1FFFFF);
      chk("R4 full and clear", and_masks[2*64 +: 64], 0);
      evt_cnt = 16'd6;
      fire();
      chk("R4 no full", 64'(chan_mask), 64'h4);
      cfg_full_n = 0; evt_cnt = 16'd1;
      fire();
      chk("R4 disabled", 64'(chan_mask), 64'h4);
      cfg_full_n = 3; evt_cnt = 16'd9;
      fire();
      chk("R4 n3 full", 64'(chan_mask), 64'h1FFFFF);
   endtask

   task automatic t_trk();
      clear_in();
      trk_pos[0 +: 5] = 5'd4;  trk_hits[0 +: 4] = 4'd0;
      trk_pos[5 +: 5] = 5'd18; trk_hits[4 +: 4] = 4'd5;
      cfg_trk_mode = 1;
      fire();
      chk("R6 three and four", 64'(chan_mask), 64'h1E0038);
      cfg_trk_mode = 0;
      fire();
      chk("R7 mode off", 64'(chan_mask), 0);
      cfg_trk_mode = 3;
      fire();
      chk("R7 mode reserved", 64'(chan_mask), 0);
      cfg_trk_mode = 2;
      trk_word[0 +: 32] = 32'h0000_1234;
      trk_word[32 +: 32] = 32'hFFFF_FFFF;
      fire();
      chk("R7 sent only", 64'(chan_mask), 64'h38);
      clear_in();
      cfg_trk_mode = 1;
      trk_pos[10 +: 5] = 5'd20; trk_hits[8 +: 4] = 4'd1;
      fire();
      chk("R8 edge discard", 64'(chan_mask), 64'h180000);
   endtask

   task automatic t_mask();
      clear_in();
      smp_mask = '1;
      ind_bmp[0] = 1'b1;
      ind_bmp[7*64] = 1'b1;
      en_mask = 21'h00000F; cfg_en_apply = 1;
      force_mask = 21'h100000;
      fire();
      chk("R9 enable applied", 64'(chan_mask), 64'h100001);
      chk("R10 force", 64'(chan_mask[20]), 1);
      cfg_en_apply = 0;
      fire();
      chk("R9 enable bypass", 64'(chan_mask), 64'h100081);
   endtask

   task automatic t_hold();
      clear_in();
      ind_bmp = '1; smp_mask = '1;
      repeat (3) @(negedge clk);
      chk("R11 hold mask", 64'(chan_mask), 64'h100081);
      chk("R11 hold and", and_masks[7*64 +: 64], 64'd1);
      chk("R11 no done", 64'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_scan();
      t_full();
      t_trk();
      t_mask();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule